// File: doc/BRIEF.md
# Graphics Domain Reset Controller

This block holds the control register that software uses to reset parts of a graphics subsystem. A two-bit selector picks a group of clock domains, and a go bit launches the reset. Once launched, the block drives the matching reset outputs for a fixed number of clock cycles. When the pulse ends, the block clears the go bit without software help. Software polls the go bit to learn when the reset has finished.

The register can be reached three ways. Software can read and write it at a primary configuration offset, read it through a mirror configuration offset, and read or write it through a memory-mapped (MMIO) offset. Configuration accesses keep working while a reset is in progress. During that time, MMIO reads return zero and MMIO writes are discarded, and a flag reports each refused access. Read data and the refusal flag are registered, so both arrive one cycle after the access.

Top module: `gfx_domain_rst_ctrl`

## Requirements
- R1: After reset, all three reset outputs and `mmio_refused` are low, and the control register reads 00h.
- R2: Selector code 00 (register bits 3:2) together with go (bit 0) asserts `rst_render` and `rst_display`, and leaves `rst_media` low.
- R3: Selector code 01 with go asserts only `rst_render`.
- R4: Selector code 11 with go asserts only `rst_media`.
- R5: Selector code 10 is invalid. Setting go with it asserts no reset output, and the go bit reads 0 again from the second cycle after the write.
- R6: For a valid code, the outputs rise in the cycle after the accepted write and stay high for exactly `HOLD_CYC` cycles. The go bit stays 1 for one more cycle after the release and then reads 0.
- R7: While the go bit is 1, writes to the register from any path are ignored. This covers both the go bit and the selector field.
- R8: Bits 7:4 and bit 1 always read 0, whatever value was written.
- R9: Configuration reads at `CFG_PRI_OFS` keep returning the live register value while a reset is in progress.
- R10: While go is 1, any MMIO access is refused: a read returns 0, a write is dropped, and `mmio_refused` is high in the following cycle. When go is 0, MMIO at `MMIO_CTRL_OFS` reads and writes the register, and `mmio_refused` stays low.
- R11: A read at `CFG_MIR_OFS` returns the same value as `CFG_PRI_OFS`. A write to `CFG_MIR_OFS` changes nothing and starts no reset.
- R12: `rdata` holds the read value in the cycle after `rd_en`. It is 0 when no read was made or when the address maps to nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Access targets configuration space (wins over `mmio_sel`) |
| mmio_sel | input | 1 | Access targets MMIO space |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset within the selected space |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mmio_refused | output | 1 | One-cycle flag: the previous MMIO access was refused |
| rst_render | output | 1 | Render domain reset, active high |
| rst_display | output | 1 | Display domain reset, active high |
| rst_media | output | 1 | Media domain reset, active high |

## Verification
Take an accepted write captured at clock edge N. The reset outputs are due just after edge N, and they fall after edge N+`HOLD_CYC`. The go bit becomes 0 after edge N+`HOLD_CYC`+1, or after edge N+1 for code 10. Read data and `mmio_refused` always lag their access by one edge, so a register read shows the register value from before the edge that captures the read. The bench drives every input on the falling edge and samples on the next falling edge. It sweeps all 256 write values with the read strobe held high, and it compares each cycle `t` after the write against an expected go value computed for `t-1`.

// File: rtl/gdr_pkg.sv
package gdr_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned GO_BIT  = 0;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RNDR_DISP = 2'b00,
    SEL_RNDR      = 2'b01,
    SEL_BAD       = 2'b10,
    SEL_MEDIA     = 2'b11
  } dom_sel_e;

  typedef struct packed {
    logic render;
    logic display;
    logic media;
  } dom_rst_t;

  function automatic logic sel_is_valid(input dom_sel_e sel);
    return sel != SEL_BAD;
  endfunction

  function automatic dom_rst_t sel_to_resets(input dom_sel_e sel);
    dom_rst_t r;
    r = '0;
    unique case (sel)
      SEL_RNDR_DISP: begin r.render = 1'b1; r.display = 1'b1; end
      SEL_RNDR:      r.render = 1'b1;
      SEL_MEDIA:     r.media  = 1'b1;
      default:       r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input dom_sel_e sel, input logic go);
    logic [REG_W-1:0] v;
    v = '0;
    v[SEL_LSB +: SEL_W] = sel;
    v[GO_BIT] = go;
    return v;
  endfunction

endpackage

// File: rtl/gdr_ctrl_reg.sv
module gdr_ctrl_reg
  import gdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             done_i,
  output dom_sel_e         sel_q,
  output logic             go_q,
  output logic             start_o,
  output logic             start_valid_o,
  output logic [REG_W-1:0] ctrl_value
);

  logic     accept;
  dom_sel_e wr_sel;

  assign wr_sel        = dom_sel_e'(ctrl_wdata[SEL_LSB +: SEL_W]);
  assign accept        = ctrl_we && !go_q;
  assign start_o       = accept && ctrl_wdata[GO_BIT];
  assign start_valid_o = sel_is_valid(wr_sel);
  assign ctrl_value    = pack_ctrl(sel_q, go_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RNDR_DISP;
      go_q  <= 1'b0;
    end else if (accept) begin
      sel_q <= wr_sel;
      go_q  <= ctrl_wdata[GO_BIT];
    end else if (done_i) begin
      go_q  <= 1'b0;
    end
  end

  // R6
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !go_q);

  // R7
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !done_i) |=> ($stable(sel_q) && go_q));

endmodule

// File: rtl/gdr_hold_seq.sv
module gdr_hold_seq #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_valid_i,
  output logic busy_q,
  output logic done_q
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !start_valid_i) begin
        done_q <= 1'b1;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else if (last_cycle) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R6
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R5
  invalid_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !start_valid_i) |=> (!busy_q && done_q));

endmodule

// File: rtl/gdr_access.sv
module gdr_access
  import gdr_pkg::*;
#(
  parameter logic [7:0] CFG_PRI_OFS   = 8'h44,
  parameter logic [7:0] CFG_MIR_OFS   = 8'hA4,
  parameter logic [7:0] MMIO_CTRL_OFS = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             mmio_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] ctrl_value,
  input  logic             in_prog,
  output logic             ctrl_we,
  output logic [REG_W-1:0] ctrl_wdata,
  output logic [REG_W-1:0] rdata_q,
  output logic             refused_q
);

  logic             hit_pri, hit_mir, mmio_act, hit_mmio, mmio_block;
  logic [REG_W-1:0] rd_val;

  assign hit_pri    = cfg_sel && (addr == CFG_PRI_OFS);
  assign hit_mir    = cfg_sel && (addr == CFG_MIR_OFS);
  assign mmio_act   = !cfg_sel && mmio_sel;
  assign hit_mmio   = mmio_act && (addr == MMIO_CTRL_OFS);
  assign mmio_block = mmio_act && (wr_en || rd_en) && in_prog;

  assign ctrl_we    = wr_en && (hit_pri || (hit_mmio && !in_prog));
  assign ctrl_wdata = wdata;

  always_comb begin
    rd_val = '0;
    if (hit_pri || hit_mir)          rd_val = ctrl_value;
    else if (hit_mmio && !in_prog)   rd_val = ctrl_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      refused_q <= 1'b0;
    end else begin
      rdata_q   <= rd_en ? rd_val : '0;
      refused_q <= mmio_block;
    end
  end

  // R10
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused_q |-> (rdata_q == '0));

  // R10
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_act && in_prog) |-> !(ctrl_we));

endmodule

// File: rtl/gfx_domain_rst_ctrl.sv
module gfx_domain_rst_ctrl
  import gdr_pkg::*;
#(
  parameter int unsigned HOLD_CYC      = 16,
  parameter logic [7:0]  CFG_PRI_OFS   = 8'h44,
  parameter logic [7:0]  CFG_MIR_OFS   = 8'hA4,
  parameter logic [7:0]  MMIO_CTRL_OFS = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sel,
  input  logic       mmio_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       mmio_refused,
  output logic       rst_render,
  output logic       rst_display,
  output logic       rst_media
);

  logic             ctrl_we, go_q, start, start_valid, busy, done;
  logic [REG_W-1:0] ctrl_wdata, ctrl_value;
  dom_sel_e         sel_q;
  dom_rst_t         dom_rst;

  gdr_access #(
    .CFG_PRI_OFS  (CFG_PRI_OFS),
    .CFG_MIR_OFS  (CFG_MIR_OFS),
    .MMIO_CTRL_OFS(MMIO_CTRL_OFS)
  ) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .mmio_sel  (mmio_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .ctrl_value(ctrl_value),
    .in_prog   (go_q),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(ctrl_wdata),
    .rdata_q   (rdata),
    .refused_q (mmio_refused)
  );

  gdr_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .done_i       (done),
    .sel_q        (sel_q),
    .go_q         (go_q),
    .start_o      (start),
    .start_valid_o(start_valid),
    .ctrl_value   (ctrl_value)
  );

  gdr_hold_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .start_valid_i(start_valid),
    .busy_q       (busy),
    .done_q       (done)
  );

  assign dom_rst     = busy ? sel_to_resets(sel_q) : '0;
  assign rst_render  = dom_rst.render;
  assign rst_display = dom_rst.display;
  assign rst_media   = dom_rst.media;

  // R4
  media_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_media |-> !(rst_render || rst_display));

  // R3
  display_needs_render_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_display |-> rst_render);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[7:4] == 4'h0) && !rdata[1]);

  // R7
  reset_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_render || rst_display || rst_media) |-> go_q);

endmodule

// File: tb/gfx_domain_rst_ctrl_tb.sv
module gfx_domain_rst_ctrl_tb;

  localparam int H = 5;
  localparam logic [7:0] PRI = 8'h44;
  localparam logic [7:0] MIR = 8'hA4;
  localparam logic [7:0] MMO = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sel = 1'b0, mmio_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       mmio_refused, rst_render, rst_display, rst_media;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gfx_domain_rst_ctrl #(
    .HOLD_CYC(H), .CFG_PRI_OFS(PRI), .CFG_MIR_OFS(MIR), .MMIO_CTRL_OFS(MMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .mmio_sel(mmio_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mmio_refused(mmio_refused),
    .rst_render(rst_render), .rst_display(rst_display), .rst_media(rst_media)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_rst(input logic [1:0] code);
    case (code)
      2'b00: return 3'b110;
      2'b01: return 3'b100;
      2'b11: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // go bit value held by the register t edges after the write edge
  function automatic logic exp_go(input logic [7:0] v, input int t);
    if (!v[0]) return 1'b0;
    if (v[3:2] == 2'b10) return (t == 0);
    return (t <= H);
  endfunction

  task automatic access(input logic mm, input logic wr, input logic rd,
                        input logic [7:0] a, input logic [7:0] d);
    cfg_sel = !mm; mmio_sel = mm; wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(negedge clk);
    cfg_sel = 0; mmio_sel = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
  endtask

  function automatic logic [2:0] rst_vec();
    return {rst_render, rst_display, rst_media};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 resets", rst_vec(), 3'b000);
    chk("R1 refused", mmio_refused, 1'b0);
    chk("R1 rdata idle", rdata, 8'h00);
    access(0, 0, 1, PRI, 8'h00);
    chk("R1 reg value", rdata, 8'h00);

    // Sweep all write values: R2 R3 R4 R5 R6 R8 R12
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      logic [7:0] expv;
      vb = 8'(v);
      cfg_sel = 1; rd_en = 1; addr = PRI; wdata = vb; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
      for (int t = 0; t < H + 4; t++) begin
        logic [2:0] er;
        er = (exp_go(vb, 0) && t < H && vb[3:2] != 2'b10) ? exp_rst(vb[3:2]) : 3'b000;
        chk(vb[3:2] == 2'b00 ? "R2 resets" : vb[3:2] == 2'b01 ? "R3 resets" :
            vb[3:2] == 2'b11 ? "R4 resets" : "R5 resets", rst_vec(), er);
        if (t >= 1) begin
          expv = {4'h0, vb[3:2], 1'b0, exp_go(vb, t - 1)};
          chk(vb[3:2] == 2'b10 ? "R5 go/readback" : "R6 R8 go/readback", rdata, expv);
        end
        @(negedge clk);
      end
    end
    cfg_sel = 0; rd_en = 0; addr = '0;
    @(negedge clk);
    chk("R12 rdata without read", rdata, 8'h00);

    // R7 locked writes
    access(0, 1, 0, PRI, 8'h05);
    access(0, 1, 0, PRI, 8'h0D);
    chk("R7 media not started", rst_media, 1'b0);
    chk("R7 render still held", rst_render, 1'b1);
    repeat (H + 1) @(negedge clk);
    access(0, 0, 1, PRI, 8'h00);
    chk("R7 field kept", rdata, 8'h04);

    // R9 R10 access during reset
    access(0, 1, 0, PRI, 8'h05);
    access(0, 0, 1, PRI, 8'h00);
    chk("R9 cfg read live", rdata, 8'h05);
    access(1, 0, 1, MMO, 8'h00);
    chk("R10 mmio read zero", rdata, 8'h00);
    chk("R10 read refused", mmio_refused, 1'b1);
    access(1, 1, 0, MMO, 8'h0C);
    chk("R10 write refused", mmio_refused, 1'b1);
    @(negedge clk);
    chk("R10 flag one cycle", mmio_refused, 1'b0);
    repeat (H) @(negedge clk);
    access(1, 0, 1, MMO, 8'h00);
    chk("R10 idle mmio read", rdata, 8'h04);
    chk("R10 idle not refused", mmio_refused, 1'b0);
    access(1, 1, 0, MMO, 8'h08);
    chk("R10 idle write no flag", mmio_refused, 1'b0);
    access(0, 0, 1, PRI, 8'h00);
    chk("R10 mmio write landed", rdata, 8'h08);
    access(1, 1, 0, MMO, 8'h0F);
    chk("R10 mmio go media", rst_vec(), 3'b001);
    repeat (H + 2) @(negedge clk);

    // R11 mirror
    access(0, 1, 0, MIR, 8'h01);
    chk("R11 mirror write no reset", rst_vec(), 3'b000);
    access(0, 0, 1, PRI, 8'h00);
    chk("R11 primary unchanged", rdata, 8'h0C);
    access(0, 0, 1, MIR, 8'h00);
    chk("R11 mirror equals primary", rdata, 8'h0C);

    // R12 unmapped reads
    access(0, 0, 1, 8'h00, 8'h00);
    chk("R12 cfg unmapped", rdata, 8'h00);
    access(1, 0, 1, 8'h20, 8'h00);
    chk("R12 mmio unmapped", rdata, 8'h00);
    chk("R12 mmio unmapped no flag", mmio_refused, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule